// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

A full-duplex synchronous serial port with independent transmit and receive sections. Each direction has its own bit clock pin and frame-sync pin, its own word length and its own clock and frame-sync polarity. All port pins are sampled in the system clock domain. The serial bit clocks must therefore run at no more than a quarter of the system clock rate, and polarity changes are made only while the direction is idle.

On the transmit side, the CPU or DMA writes a word into a holding register. At the next frame the word moves into a shift register and is sent most significant bit first. On the receive side, bits collect in a shift register. A finished word passes to a buffer stage and then to a read register. Because of these three stages, software can move data while the next word is still on the wire. A 16-bit register bus gives access to data, control and status. Transmit and receive each have a one-cycle interrupt strobe and a one-cycle DMA event strobe.

Top module: `ser_port`

## Requirements
- R1: Transmit and receive run at the same time, each on its own clock and frame-sync pins with its own control fields, and neither disturbs the other.
- R2: A direction's word length comes from its 3-bit length code: 0=8, 1=12, 2=16, 3=20, 4=24, 5..7=32 bits. Transmit sends the low N bits of the word. Receive right-justifies the N bits in the 32-bit read register and clears the bits above them.
- R3: Data goes out most significant bit first. Frame sync is sampled on the sample edge. The first bit is driven on the next launch edge and each later bit on the following launch edges. A receiver samples its first bit on the sample edge after the one that saw frame sync. `dx_o` is 0 outside a word.
- R4: When a clock-polarity bit is 0, launch is the rising pin edge and sample is the falling pin edge; when it is 1 they swap. When a frame-sync polarity bit is 0 the frame sync is active high; when it is 1 it is active low.
- R5: Bus map. Address 0 writes the low half of the transmit word and reads the low half of the read register. Address 1 writes the high half of the transmit word and reads the high half of the read register. Address 2 is control, readable: [2:0] receive length, [3] receive clock polarity, [4] receive frame-sync polarity, [7:5] transmit length, [8] transmit clock polarity, [9] transmit frame-sync polarity. Address 3 is status. Reads are combinational.
- R6: A write to address 0 commits {high half, written data} to the holding register and clears transmit-ready (status bit 0). When a frame takes the word into the shift register, transmit-ready sets, and `xint_o` and `xevt_o` pulse together for one cycle.
- R7: A word written while the previous word is shifting does not disturb that word and is sent in the next frame.
- R8: When a word reaches the read register, receive-ready (status bit 1) sets, and `rint_o` and `revt_o` pulse together for one cycle. A read of address 0 clears receive-ready, after which a word waiting in the buffer stage moves up.
- R9: A word that completes while both the buffer stage and the read register are full is dropped. Overrun (status bit 2) sets and the read register keeps its word. Writing 1 to status bit 2 clears it.
- R10: A frame that starts with the holding register empty resends the previous word (0 after reset), sets underflow (status bit 3) and gives no transmit pulse. Writing 1 to status bit 3 clears it.
- R11: After reset, status reads 0x0001, control reads 0, and `dx_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational) |
| xclk_i | input | 1 | Transmit bit clock pin |
| xfs_i | input | 1 | Transmit frame-sync pin |
| dx_o | output | 1 | Transmit data pin |
| rclk_i | input | 1 | Receive bit clock pin |
| rfs_i | input | 1 | Receive frame-sync pin |
| dr_i | input | 1 | Receive data pin |
| xint_o | output | 1 | Transmit interrupt strobe |
| xevt_o | output | 1 | Transmit DMA event strobe |
| rint_o | output | 1 | Receive interrupt strobe |
| revt_o | output | 1 | Receive DMA event strobe |

## Verification
A transmit launch edge becomes visible at the first system clock rising edge after the pin changes. That same edge updates `dx_o`, sets transmit-ready and raises the transmit strobes. A received word is in the read register, with receive-ready set and the receive strobes high, after the third rising edge that follows its last sample edge. Register writes take effect on the next rising edge. The bench holds each serial half-period for four system cycles. It reads `dx_o` at the falling bench clock, four cycles after the launch, and it reads back status or data only after at least four idle cycles have passed. Every due value has therefore settled before it is sampled. A monitor pops the expected transmit words from a queue as frames finish, and strobe counts are compared after each step.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int WORD_W = 32;
  localparam int BUS_W  = 16;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  typedef struct packed {
    logic             fs_pol;
    logic             clk_pol;
    logic [LEN_W-1:0] len;
  } dir_cfg_t;

  localparam int CFG_W  = $bits(dir_cfg_t);
  localparam int CTRL_W = 2 * CFG_W;

  typedef enum logic [1:0] {
    A_DATA_LO = 2'd0,
    A_DATA_HI = 2'd1,
    A_CTRL    = 2'd2,
    A_STAT    = 2'd3
  } reg_addr_e;

  localparam int ST_XRDY = 0;
  localparam int ST_RRDY = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_UND  = 3;

  function automatic logic [CNT_W-1:0] code_bits(input logic [LEN_W-1:0] c);
    case (c)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(12);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(WORD_W);
    endcase
  endfunction
endpackage

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_pin_i,
  input  logic              fs_pin_i,
  input  dir_cfg_t          cfg_i,
  input  logic              hold_vld_i,
  input  logic [WORD_W-1:0] hold_i,
  output logic              take_o,
  output logic              under_o,
  output logic              dx_o
);
  logic eff, eff_q, launch, sample, fs_act, start;
  logic pend_q, act_q;
  logic [CNT_W-1:0]  cnt_q, nbits;
  logic [WORD_W-1:0] sh_q, last_q, next_w;

  assign eff    = clk_pin_i ^ cfg_i.clk_pol;
  assign launch = eff & ~eff_q;
  assign sample = ~eff & eff_q;
  assign fs_act = fs_pin_i ^ cfg_i.fs_pol;
  assign nbits  = code_bits(cfg_i.len);
  assign start  = launch & pend_q;
  // empty holding register: repeat last word
  assign next_w = hold_vld_i ? hold_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      last_q <= '0;
    end else begin
      eff_q <= eff;
      if (sample && fs_act) pend_q <= 1'b1;
      else if (start)       pend_q <= 1'b0;
      if (start) begin
        last_q <= next_w;
        sh_q   <= next_w << (CNT_W'(WORD_W) - nbits);
        cnt_q  <= nbits - CNT_W'(1);
        act_q  <= 1'b1;
      end else if (launch && act_q) begin
        if (cnt_q == '0) begin
          act_q <= 1'b0;
        end else begin
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  assign take_o  = start & hold_vld_i;
  assign under_o = start & ~hold_vld_i;
  assign dx_o    = act_q & sh_q[WORD_W-1];
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_pin_i,
  input  logic              fs_pin_i,
  input  logic              dr_i,
  input  dir_cfg_t          cfg_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  logic eff, eff_q, sample, fs_act, last_bit;
  logic busy_q;
  logic [CNT_W-1:0]  cnt_q, nbits;
  logic [WORD_W-1:0] sh_q, sh_n;

  assign eff      = clk_pin_i ^ cfg_i.clk_pol;
  assign sample   = ~eff & eff_q;
  assign fs_act   = fs_pin_i ^ cfg_i.fs_pol;
  assign nbits    = code_bits(cfg_i.len);
  assign sh_n     = {sh_q[WORD_W-2:0], dr_i};
  assign last_bit = busy_q && ((cnt_q + CNT_W'(1)) == nbits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      word_o <= '0;
    end else begin
      eff_q  <= eff;
      done_o <= 1'b0;
      if (sample) begin
        if (busy_q) begin
          sh_q  <= sh_n;
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_bit) begin
            done_o <= 1'b1;
            word_o <= sh_n;
            busy_q <= 1'b0;
          end
        end
        // frame sync rearms, also on the last bit of a word
        if (fs_act) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          sh_q   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sp_rx_stage.sv
module sp_rx_stage
  import sp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pop_i,
  output logic              rrdy_o,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              move_o,
  output logic              ovr_o
);
  logic              buf_vld_q;
  logic [WORD_W-1:0] buf_q;

  assign move_o = buf_vld_q & ~rrdy_o;
  assign ovr_o  = done_i & buf_vld_q & ~move_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_vld_q <= 1'b0;
      buf_q     <= '0;
      rrdy_o    <= 1'b0;
      rd_word_o <= '0;
    end else begin
      if (done_i && (!buf_vld_q || move_o)) begin
        buf_q     <= word_i;
        buf_vld_q <= 1'b1;
      end else if (move_o) begin
        buf_vld_q <= 1'b0;
      end
      if (move_o) begin
        rd_word_o <= buf_q;
        rrdy_o    <= 1'b1;
      end else if (pop_i) begin
        rrdy_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_port.sv
module ser_port
  import sp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             xclk_i,
  input  logic             xfs_i,
  output logic             dx_o,
  input  logic             rclk_i,
  input  logic             rfs_i,
  input  logic             dr_i,
  output logic             xint_o,
  output logic             xevt_o,
  output logic             rint_o,
  output logic             revt_o
);
  reg_addr_e         addr;
  logic              wr_lo, wr_hi, wr_ctrl, wr_stat, rd_lo;
  logic [BUS_W-1:0]  hi_q;
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;
  logic [CTRL_W-1:0] ctrl_q;
  dir_cfg_t          tx_cfg, rx_cfg;
  logic              take, under, und_q, ovr_q, xpulse_q, rpulse_q;
  logic              rx_done, rrdy, move, ovr_hit;
  logic [WORD_W-1:0] rx_word, rd_word;

  assign addr    = reg_addr_e'(addr_i);
  assign wr_lo   = wr_i && addr == A_DATA_LO;
  assign wr_hi   = wr_i && addr == A_DATA_HI;
  assign wr_ctrl = wr_i && addr == A_CTRL;
  assign wr_stat = wr_i && addr == A_STAT;
  assign rd_lo   = rd_i && addr == A_DATA_LO;
  assign rx_cfg  = dir_cfg_t'(ctrl_q[CFG_W-1:0]);
  assign tx_cfg  = dir_cfg_t'(ctrl_q[CTRL_W-1:CFG_W]);

  sp_tx u_tx (
    .clk_i, .rst_ni,
    .clk_pin_i (xclk_i),
    .fs_pin_i  (xfs_i),
    .cfg_i     (tx_cfg),
    .hold_vld_i(hold_vld_q),
    .hold_i    (hold_q),
    .take_o    (take),
    .under_o   (under),
    .dx_o      (dx_o)
  );

  sp_rx u_rx (
    .clk_i, .rst_ni,
    .clk_pin_i(rclk_i),
    .fs_pin_i (rfs_i),
    .dr_i     (dr_i),
    .cfg_i    (rx_cfg),
    .done_o   (rx_done),
    .word_o   (rx_word)
  );

  sp_rx_stage u_rxq (
    .clk_i, .rst_ni,
    .done_i   (rx_done),
    .word_i   (rx_word),
    .pop_i    (rd_lo),
    .rrdy_o   (rrdy),
    .rd_word_o(rd_word),
    .move_o   (move),
    .ovr_o    (ovr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q       <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      ctrl_q     <= '0;
      und_q      <= 1'b0;
      ovr_q      <= 1'b0;
      xpulse_q   <= 1'b0;
      rpulse_q   <= 1'b0;
    end else begin
      if (wr_hi) hi_q <= wdata_i;
      // a write in the same cycle as a take refills the holding register
      if (wr_lo) begin
        hold_q     <= {hi_q, wdata_i};
        hold_vld_q <= 1'b1;
      end else if (take) begin
        hold_vld_q <= 1'b0;
      end
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (under)                           und_q <= 1'b1;
      else if (wr_stat && wdata_i[ST_UND]) und_q <= 1'b0;
      if (ovr_hit)                         ovr_q <= 1'b1;
      else if (wr_stat && wdata_i[ST_OVR]) ovr_q <= 1'b0;
      xpulse_q <= take;
      rpulse_q <= move;
    end
  end

  assign xint_o = xpulse_q;
  assign xevt_o = xpulse_q;
  assign rint_o = rpulse_q;
  assign revt_o = rpulse_q;

  always_comb begin
    rdata_o = '0;
    case (addr)
      A_DATA_LO: rdata_o = rd_word[BUS_W-1:0];
      A_DATA_HI: rdata_o = rd_word[WORD_W-1:BUS_W];
      A_CTRL:    rdata_o = BUS_W'(ctrl_q);
      A_STAT: begin
        rdata_o[ST_XRDY] = ~hold_vld_q;
        rdata_o[ST_RRDY] = rrdy;
        rdata_o[ST_OVR]  = ovr_q;
        rdata_o[ST_UND]  = und_q;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hold_vld,
  input logic        rrdy,
  input logic [31:0] rd_word,
  input logic        rd_i,
  input logic [1:0]  addr_i,
  input logic        xint_o,
  input logic        rint_o,
  input logic        und
);
  // R6
  xrdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_vld) |-> xint_o);

  // R6
  xint_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xint_o |=> !xint_o);

  // R8
  rrdy_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rrdy) |-> rint_o);

  // R8
  rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rrdy && rd_i && addr_i == 2'd0) |=> !rrdy);

  // R9
  rd_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rrdy && $past(rrdy)) |-> $stable(rd_word));

  // R10
  und_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(und) |-> !xint_o);
endmodule

bind ser_port ser_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hold_vld(hold_vld_q),
  .rrdy    (rrdy),
  .rd_word (rd_word),
  .rd_i    (rd_i),
  .addr_i  (addr_i),
  .xint_o  (xint_o),
  .rint_o  (rint_o),
  .und     (und_q)
);

// File: tb/tb_ser_port.sv
module tb_ser_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [1:0]  addr;
  logic        wr, rd;
  logic [15:0] wdata, rdata;
  logic tx_c = 1'b1, tx_cpol = 1'b0, tx_fsa = 1'b0, tx_fspol = 1'b0;
  logic rx_c = 1'b1, rx_cpol = 1'b0, rx_fsa = 1'b0, rx_fspol = 1'b0, rx_d = 1'b0;
  logic xclk, xfs, rclk, rfs, dx, xint, xevt, rint, revt;

  assign xclk = tx_c ^ tx_cpol;
  assign xfs  = tx_fsa ^ tx_fspol;
  assign rclk = rx_c ^ rx_cpol;
  assign rfs  = rx_fsa ^ rx_fspol;

  ser_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .xclk_i(xclk), .xfs_i(xfs), .dx_o(dx),
    .rclk_i(rclk), .rfs_i(rfs), .dr_i(rx_d), .xint_o(xint), .xevt_o(xevt),
    .rint_o(rint), .revt_o(revt)
  );

  int checks = 0, errors = 0;
  int xint_n = 0, rint_n = 0, evt_mis = 0;
  int tx_bits = 8;
  bit fin = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic push(input string t, input logic [31:0] w, input int n);
    logic [31:0] m;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    exp_q.push_back(w & m);
    tag_q.push_back(t);
  endtask

  task automatic tx_frame(input int n);
    tx_bits = n;
    tx_fsa = 1'b1; tick(4);
    tx_c = 1'b0;   tick(4);
    tx_c = 1'b1; tx_fsa = 1'b0; tick(4);
    repeat (n) begin
      tx_c = 1'b0; tick(4);
      tx_c = 1'b1; tick(4);
    end
  endtask

  task automatic rx_frame(input logic [31:0] w, input int n);
    rx_fsa = 1'b1; tick(4);
    rx_c = 1'b0;   tick(4);
    rx_c = 1'b1; rx_d = w[n-1]; rx_fsa = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      rx_c = 1'b0; tick(4);
      rx_c = 1'b1;
      if (i > 0) rx_d = w[i-1];
      tick(4);
    end
  endtask

  // monitor: decodes dx on the bench's own sample edges
  logic [31:0] mon_w = '0;
  int          mon_n = 0;
  bit          mon_on = 1'b0;
  always @(negedge tx_c) begin
    if (mon_on) begin
      mon_w = {mon_w[30:0], dx};
      mon_n++;
      if (mon_n == tx_bits) begin
        mon_on = 1'b0;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 unexpected word actual=%h expected=none", mon_w);
        end else begin
          chk(tag_q.pop_front(), mon_w, exp_q.pop_front());
        end
      end
    end
    if (tx_fsa) begin
      mon_on = 1'b1; mon_n = 0; mon_w = '0;
    end
  end

  always @(posedge clk) begin
    if (xint === 1'b1) xint_n++;
    if (rint === 1'b1) rint_n++;
    if (xint !== xevt || rint !== revt) evt_mis++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = 2'd0; wdata = '0;
    tick(5); rst_n = 1'b1; tick(2);

    // R11 reset state
    bus_rd(2'd3, d); chk("R11 status", 32'(d), 32'h1);
    bus_rd(2'd2, d); chk("R11 ctrl", 32'(d), 32'h0);
    chk("R11 dx idle", 32'(dx), 32'h0);
    chk("R11 no strobes", 32'(xint_n + rint_n), 32'h0);

    // R3 / R6: 8-bit word, default polarity
    bus_wr(2'd0, 16'h00A5);
    bus_rd(2'd3, d); chk("R6 xrdy clears on write", 32'(d[0]), 32'h0);
    push("R3 msb first 8b", 32'h0000_00A5, 8);
    tx_frame(8); tick(2);
    bus_rd(2'd3, d); chk("R6 xrdy sets on take", 32'(d[0]), 32'h1);
    chk("R6 xint count", 32'(xint_n), 32'h1);

    // R2: 32-bit transmit
    bus_wr(2'd2, 16'h00A0);
    bus_wr(2'd1, 16'hDEAD);
    bus_wr(2'd0, 16'hBEEF);
    push("R2 32b tx", 32'hDEAD_BEEF, 32);
    tx_frame(32); tick(2);
    chk("R6 xint count 32b", 32'(xint_n), 32'h2);

    // R4: 12-bit, inverted clock and frame sync
    bus_wr(2'd2, 16'h0320);
    tx_cpol = 1'b1; tx_fspol = 1'b1;
    bus_wr(2'd0, 16'h0ABC);
    push("R4 inverted 12b tx", 32'h0000_0ABC, 12);
    tx_frame(12);

    // R7: write during shift
    bus_wr(2'd0, 16'h0123);
    push("R7 first word", 32'h0000_0123, 12);
    push("R7 second word", 32'h0000_0456, 12);
    fork
      tx_frame(12);
      begin tick(40); bus_wr(2'd0, 16'h0456); end
    join
    bus_rd(2'd3, d); chk("R7 second word held", 32'(d[0]), 32'h0);
    tx_frame(12); tick(2);
    chk("R7 xint count", 32'(xint_n), 32'h5);

    // R10: underflow repeats last word
    push("R10 repeated word", 32'h0000_0456, 12);
    tx_frame(12); tick(2);
    bus_rd(2'd3, d); chk("R10 underflow set", 32'(d[3]), 32'h1);
    chk("R10 no xint", 32'(xint_n), 32'h5);
    bus_wr(2'd3, 16'h0008);
    bus_rd(2'd3, d); chk("R10 underflow cleared", 32'(d[3]), 32'h0);

    bus_wr(2'd2, 16'h0000);
    tx_cpol = 1'b0; tx_fspol = 1'b0;

    // R8: 8-bit receive
    rx_frame(32'h3C, 8); tick(4);
    bus_rd(2'd3, d); chk("R8 rrdy set", 32'(d[1]), 32'h1);
    chk("R8 rint count", 32'(rint_n), 32'h1);
    bus_rd(2'd1, d); chk("R2 rx upper zero", 32'(d), 32'h0);
    bus_rd(2'd0, d); chk("R8 rx data", 32'(d), 32'h3C);
    bus_rd(2'd3, d); chk("R8 rrdy clears on read", 32'(d[1]), 32'h0);

    // R4 / R2: 20-bit receive, inverted polarity
    bus_wr(2'd2, 16'h001B);
    rx_cpol = 1'b1; rx_fspol = 1'b1;
    rx_frame(32'h000F_1234, 20); tick(4);
    bus_rd(2'd1, d); chk("R4 rx inverted hi", 32'(d), 32'h000F);
    bus_rd(2'd0, d); chk("R2 rx 20b lo", 32'(d), 32'h1234);

    // R9: overrun
    bus_wr(2'd2, 16'h0002);
    rx_cpol = 1'b0; rx_fspol = 1'b0;
    rx_frame(32'h1111, 16);
    rx_frame(32'h2222, 16);
    rx_frame(32'h3333, 16); tick(4);
    bus_rd(2'd3, d); chk("R9 overrun and rrdy", 32'(d[2:1]), 32'h3);
    bus_rd(2'd0, d); chk("R9 first word kept", 32'(d), 32'h1111);
    bus_rd(2'd3, d); chk("R8 buffered word moves up", 32'(d[1]), 32'h1);
    bus_rd(2'd0, d); chk("R9 second word", 32'(d), 32'h2222);
    bus_rd(2'd3, d); chk("R9 third word dropped", 32'(d[1]), 32'h0);
    bus_wr(2'd3, 16'h0004);
    bus_rd(2'd3, d); chk("R9 overrun cleared", 32'(d[2]), 32'h0);
    chk("R8 rint total", 32'(rint_n), 32'h4);

    // R1: full duplex, different polarity per direction
    bus_wr(2'd2, 16'h004A);
    rx_cpol = 1'b1;
    bus_rd(2'd2, d); chk("R5 ctrl readback", 32'(d), 32'h004A);
    bus_wr(2'd1, 16'h0000);
    bus_wr(2'd0, 16'h1357);
    push("R1 duplex tx", 32'h1357, 16);
    fork
      tx_frame(16);
      rx_frame(32'h2468, 16);
    join
    tick(4);
    bus_rd(2'd0, d); chk("R1 duplex rx", 32'(d), 32'h2468);

    chk("R3 all tx words seen", 32'(exp_q.size()), 32'h0);
    chk("R6 event matches interrupt", 32'(evt_mis), 32'h0);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule